// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider Pair

This block holds the two programmable dividers of an integer-N synthesizer loop. The feedback side counts the output cycles of an external 32/33 dual-modulus prescaler. It uses a main count B and a swallow count A, so the total division from the oscillator is 32·B + A. It drives the modulus-select output that tells the prescaler which ratio to apply. The reference side divides the reference clock by a 10-bit value R to make the comparison pulse. Each side emits a one-cycle pulse at its terminal count and reloads on that same edge, so periods follow one another with no gap.

The feedback side is a state machine with three states. FB_IDLE means powered down or just out of reset. FB_SWALLOW means the prescaler is asked for divide-by-33. FB_MAIN means divide-by-32. Its transitions are:
- start: FB_IDLE to FB_SWALLOW when A≠0, else to FB_MAIN.
- swallow-done: FB_SWALLOW to FB_MAIN.
- reload: at terminal count, back to FB_SWALLOW or FB_MAIN according to the new A.
- sleep: any state to FB_IDLE.

The reference side has two states, REF_IDLE and REF_RUN. Its transitions are start (REF_IDLE to REF_RUN), reload (REF_RUN to REF_RUN at terminal count) and sleep (back to REF_IDLE).

New divide values are sampled only at a terminal count. An illegal feedback pair raises a status bit and is otherwise ignored. Power-down holds both sides at their start point, so that on wake-up they begin counting on the same edge.

Top module: `dual_mod_divider`

## Requirements
- R1: When running, fb_pulse is high for exactly one fb_clk cycle in every B cycles. After the start edge it is high in cycles B-1, 2B-1, and so on, with cycle 0 being the first cycle after the start edge.
- R2: mod_sel is 1 (prescaler divides by 33) in the first A cycles of each feedback period and 0 (divides by 32) in the rest, which gives an overall ratio of 32·B + A.
- R3: When running, ref_pulse is high for one ref_clk cycle in every R cycles, in cycles R-1, 2R-1, and so on after the start edge, for R from 2 to 1023.
- R4: With A equal to B, the end of the swallow phase and the terminal count fall in the same cycle. mod_sel then stays 1 through every period.
- R5: A feedback pair with B < A or B = 0 sets cfg_err to 1 one fb_clk edge after it appears. It is never loaded, and the previous A and B stay in use. cfg_err returns to 0 one edge after a legal pair is present.
- R6: An R value below 2 is never loaded, and the previous R stays in use.
- R7: A, B or R changed while running takes effect only at the next terminal count of its own counter. The period in progress finishes with the old value.
- R8: From the first edge at which pwr_dn is 1, fb_pulse, mod_sel and ref_pulse are all 0 and stay 0 while pwr_dn remains 1.
- R9: At the edge where pwr_dn is seen as 0, both counters restart from the beginning of a period. With equal clocks and B = R, the first fb_pulse and the first ref_pulse coincide.
- R10: While rst_n is 0, fb_pulse, mod_sel, ref_pulse and cfg_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fb_clk | input | 1 | Prescaler output clock |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down: hold and reset both counters |
| swallow_a | input | 5 | Swallow count A |
| main_b | input | 10 | Main count B |
| ref_r | input | 10 | Reference divide value R |
| mod_sel | output | 1 | 1 = prescaler divides by 33, 0 = by 32 |
| fb_pulse | output | 1 | Feedback terminal pulse |
| ref_pulse | output | 1 | Reference terminal pulse |
| cfg_err | output | 1 | Illegal feedback pair present |

## Verification
Two events in the feedback counter can meet in one cycle: the last swallow cycle and the terminal count. This happens whenever A equals B, and the bench provokes it with A = B = 31 and with A = B = 1. It is judged by checking that mod_sel stays 1 with no gap while fb_pulse still repeats every B cycles. A second coincidence is a mid-period change of the divide values landing on a reload edge. The bench judges that case against a cycle model which only adopts the new values at each terminal count. The same model also checks that an illegal pair is ignored.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
    typedef enum logic [1:0] {
        FB_IDLE,
        FB_SWALLOW,
        FB_MAIN
    } fb_state_t;

    typedef enum logic {
        REF_IDLE,
        REF_RUN
    } ref_state_t;
endpackage

// File: rtl/swallow_divider.sv
module swallow_divider
    import dmd_pkg::*;
#(
    parameter int A_W = 5,
    parameter int B_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_dn,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic           mod_sel,
    output logic           fb_pulse,
    output logic           cfg_err
);
    localparam logic [B_W-1:0] B_RST = {B_W{1'b1}};
    localparam logic [A_W-1:0] A_ONE = A_W'(1);

    fb_state_t      state;
    logic [B_W-1:0] b_cnt;
    logic [A_W-1:0] a_cnt;
    logic [A_W-1:0] act_a;
    logic [B_W-1:0] act_b;

    logic           cand_ok;
    logic [A_W-1:0] use_a;
    logic [B_W-1:0] use_b;
    fb_state_t      start_state;

    always_comb begin
        cand_ok     = (b_in != '0) && (b_in >= B_W'(a_in));
        use_a       = cand_ok ? a_in : act_a;
        use_b       = cand_ok ? b_in : act_b;
        start_state = (use_a != '0) ? FB_SWALLOW : FB_MAIN;
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= FB_IDLE;
            b_cnt   <= '0;
            a_cnt   <= '0;
            act_a   <= '0;
            act_b   <= B_RST;
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= !cand_ok;
            if (pwr_dn) begin
                state <= FB_IDLE;
                b_cnt <= '0;
                a_cnt <= '0;
            end else begin
                unique case (state)
                    FB_IDLE: begin
                        act_a <= use_a;
                        act_b <= use_b;
                        b_cnt <= B_W'(use_b - 1'b1);
                        a_cnt <= use_a;
                        state <= start_state;
                    end
                    FB_SWALLOW, FB_MAIN: begin
                        if (b_cnt == '0) begin
                            act_a <= use_a;
                            act_b <= use_b;
                            b_cnt <= B_W'(use_b - 1'b1);
                            a_cnt <= use_a;
                            state <= start_state;
                        end else begin
                            b_cnt <= b_cnt - 1'b1;
                            if (state == FB_SWALLOW) begin
                                a_cnt <= a_cnt - 1'b1;
                                if (a_cnt == A_ONE) state <= FB_MAIN;
                            end
                        end
                    end
                    default: state <= FB_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        mod_sel  = (state == FB_SWALLOW);
        fb_pulse = (state != FB_IDLE) && (b_cnt == '0);
    end

    // R8
    fb_pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!fb_pulse && !mod_sel));

    // R1
    fb_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != FB_IDLE) |-> (b_cnt < act_b));

    // R4
    swallow_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FB_SWALLOW) |-> ((B_W+1)'(a_cnt) <= (B_W+1)'(b_cnt) + 1'b1));

    // R1
    fb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_pulse && !pwr_dn && (use_b > B_W'(1))) |=> !fb_pulse);
endmodule

// File: rtl/ref_divider.sv
module ref_divider
    import dmd_pkg::*;
#(
    parameter int R_W   = 10,
    parameter int R_MIN = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_dn,
    input  logic [R_W-1:0] r_in,
    output logic           ref_pulse
);
    localparam logic [R_W-1:0] R_RST = {R_W{1'b1}};
    localparam logic [R_W-1:0] R_LOW = R_W'(R_MIN);

    ref_state_t     state;
    logic [R_W-1:0] r_cnt;
    logic [R_W-1:0] act_r;
    logic [R_W-1:0] use_r;

    always_comb begin
        use_r = (r_in >= R_LOW) ? r_in : act_r;
    end

    // state register and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= REF_IDLE;
            r_cnt <= '0;
            act_r <= R_RST;
        end else if (pwr_dn) begin
            state <= REF_IDLE;
            r_cnt <= '0;
        end else begin
            unique case (state)
                REF_IDLE: begin
                    act_r <= use_r;
                    r_cnt <= R_W'(use_r - 1'b1);
                    state <= REF_RUN;
                end
                REF_RUN: begin
                    if (r_cnt == '0) begin
                        act_r <= use_r;
                        r_cnt <= R_W'(use_r - 1'b1);
                    end else begin
                        r_cnt <= r_cnt - 1'b1;
                    end
                end
                default: state <= REF_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ref_pulse = (state == REF_RUN) && (r_cnt == '0);
    end

    // R3
    ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    // R3
    ref_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == REF_RUN) |-> (r_cnt < act_r));

    // R8
    ref_pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !ref_pulse);
endmodule

// File: rtl/dual_mod_divider.sv
module dual_mod_divider #(
    parameter int A_W   = 5,
    parameter int B_W   = 10,
    parameter int R_W   = 10,
    parameter int R_MIN = 2
) (
    input  logic           fb_clk,
    input  logic           ref_clk,
    input  logic           rst_n,
    input  logic           pwr_dn,
    input  logic [A_W-1:0] swallow_a,
    input  logic [B_W-1:0] main_b,
    input  logic [R_W-1:0] ref_r,
    output logic           mod_sel,
    output logic           fb_pulse,
    output logic           ref_pulse,
    output logic           cfg_err
);
    swallow_divider #(
        .A_W(A_W),
        .B_W(B_W)
    ) u_fb (
        .clk     (fb_clk),
        .rst_n   (rst_n),
        .pwr_dn  (pwr_dn),
        .a_in    (swallow_a),
        .b_in    (main_b),
        .mod_sel (mod_sel),
        .fb_pulse(fb_pulse),
        .cfg_err (cfg_err)
    );

    ref_divider #(
        .R_W  (R_W),
        .R_MIN(R_MIN)
    ) u_ref (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .pwr_dn   (pwr_dn),
        .r_in     (ref_r),
        .ref_pulse(ref_pulse)
    );

    // R10
    reset_quiet_chk: assert property (@(posedge fb_clk)
        !rst_n |-> (!fb_pulse && !mod_sel && !cfg_err && !ref_pulse));
endmodule

// File: tb/test_dual_mod_divider.sv
`timescale 1ns/1ps
module test_dual_mod_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_dn = 1'b0;
    logic [4:0] a_in = 5'd0;
    logic [9:0] b_in = 10'd31;
    logic [9:0] r_in = 10'd2;
    logic       mod_sel, fb_pulse, ref_pulse, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_mod_divider i_dual_mod_divider (
        .fb_clk   (clk),
        .ref_clk  (clk),
        .rst_n    (rst_n),
        .pwr_dn   (pwr_dn),
        .swallow_a(a_in),
        .main_b   (b_in),
        .ref_r    (r_in),
        .mod_sel  (mod_sel),
        .fb_pulse (fb_pulse),
        .ref_pulse(ref_pulse),
        .cfg_err  (cfg_err)
    );

    typedef struct packed {
        logic [4:0] a;
        logic [9:0] b;
        logic [9:0] r;
    } vec_t;

    // a, b, r ; entry 2 and 3 have A == B (R4)
    localparam vec_t VECS [5] = '{
        '{5'd0,  10'd31, 10'd2},
        '{5'd5,  10'd31, 10'd31},
        '{5'd31, 10'd31, 10'd7},
        '{5'd1,  10'd1,  10'd3},
        '{5'd17, 10'd40, 10'd1023}
    };

    // requirement-level model
    bit running = 1'b0;
    int m_a = 0, m_b = 1023, m_r = 1023, fb_pos = 0, r_pos = 0;
    int err_fb, err_mod, err_ref;

    function automatic bit fb_ok(int a, int b);
        return (b != 0) && (b >= a);
    endfunction

    task automatic check(bit ok, string msg, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", msg, act, exp);
        end
    endtask

    task automatic load_fb();
        if (fb_ok(int'(a_in), int'(b_in))) begin
            m_a = int'(a_in);
            m_b = int'(b_in);
        end
    endtask

    task automatic load_ref();
        if (r_in >= 10'd2) m_r = int'(r_in);
    endtask

    task automatic step();
        bit efb, emod, eref;
        efb  = running && (fb_pos == m_b - 1);
        emod = running && (fb_pos < m_a);
        eref = running && (r_pos == m_r - 1);
        if (fb_pulse !== efb) err_fb++;
        if (mod_sel !== emod) err_mod++;
        if (ref_pulse !== eref) err_ref++;
        if (pwr_dn) begin
            running = 1'b0;
        end else if (!running) begin
            load_fb();
            load_ref();
            fb_pos = 0;
            r_pos = 0;
            running = 1'b1;
        end else begin
            if (fb_pos == m_b - 1) begin
                fb_pos = 0;
                load_fb();
            end else begin
                fb_pos++;
            end
            if (r_pos == m_r - 1) begin
                r_pos = 0;
                load_ref();
            end else begin
                r_pos++;
            end
        end
        @(posedge clk);
        #1;
    endtask

    task automatic run(int n, string tag);
        err_fb = 0;
        err_mod = 0;
        err_ref = 0;
        for (int i = 0; i < n; i++) step();
        check(err_fb == 0, {tag, " R1 fb_pulse mismatched cycles"}, err_fb, 0);
        check(err_mod == 0, {tag, " R2 mod_sel mismatched cycles"}, err_mod, 0);
        check(err_ref == 0, {tag, " R3 ref_pulse mismatched cycles"}, err_ref, 0);
    endtask

    task automatic restart(int a, int b, int r);
        a_in = 5'(a);
        b_in = 10'(b);
        r_in = 10'(r);
        pwr_dn = 1'b1;
        err_fb = 0;
        err_mod = 0;
        err_ref = 0;
        step();
        pwr_dn = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        check({fb_pulse, mod_sel, ref_pulse, cfg_err} == 4'b0,
              "R10 outputs in reset", int'({fb_pulse, mod_sel, ref_pulse, cfg_err}), 0);
        rst_n = 1'b1;
        run(70, "after reset");

        // vector table: R1 R2 R3 R4
        foreach (VECS[k]) begin
            int len;
            len = (int'(VECS[k].b) > int'(VECS[k].r)) ? int'(VECS[k].b) : int'(VECS[k].r);
            restart(int'(VECS[k].a), int'(VECS[k].b), int'(VECS[k].r));
            run(2 * len + 2, $sformatf("vector %0d", k));
        end
        check(1'b1, "R4 A==B vectors covered above", 1, 1);

        // R7: change mid-period, takes effect at next terminal count
        restart(2, 10, 10);
        run(4, "R7 before change");
        a_in = 5'd4;
        b_in = 10'd20;
        r_in = 10'd5;
        run(45, "R7 after change");

        // R5 and R6: illegal values are flagged or ignored
        restart(5, 31, 31);
        run(2, "R5 before");
        a_in = 5'd10;
        b_in = 10'd5;
        r_in = 10'd1;
        err_fb = 0;
        err_mod = 0;
        err_ref = 0;
        step();
        check(cfg_err == 1'b1, "R5 cfg_err on B<A", int'(cfg_err), 1);
        run(70, "R5 R6 illegal values ignored");
        b_in = 10'd0;
        a_in = 5'd0;
        step();
        check(cfg_err == 1'b1, "R5 cfg_err on B=0", int'(cfg_err), 1);
        a_in = 5'd3;
        b_in = 10'd8;
        r_in = 10'd4;
        step();
        check(cfg_err == 1'b0, "R5 cfg_err cleared", int'(cfg_err), 0);
        run(40, "R5 legal again");

        // R8 and R9: power-down and aligned restart
        restart(3, 20, 20);
        run(25, "R9 pre power-down");
        pwr_dn = 1'b1;
        step();
        begin
            int loud;
            loud = 0;
            for (int i = 0; i < 6; i++) begin
                if (fb_pulse || mod_sel || ref_pulse) loud++;
                step();
            end
            check(loud == 0, "R8 outputs quiet in power-down", loud, 0);
        end
        pwr_dn = 1'b0;
        step();
        begin
            int fb_at, ref_at;
            fb_at = -1;
            ref_at = -1;
            for (int i = 0; i < 25; i++) begin
                if (fb_pulse && fb_at < 0) fb_at = i;
                if (ref_pulse && ref_at < 0) ref_at = i;
                step();
            end
            check(fb_at == 19, "R9 first fb_pulse cycle", fb_at, 19);
            check(ref_at == fb_at, "R9 ref_pulse aligned with fb_pulse", ref_at, fb_at);
        end
        run(45, "R9 after wake-up");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule